// File: doc/BRIEF.md
# Asynchronous Memory Access Timing Sequencer

This block drives the control strobes of an external asynchronous SRAM or NOR-type device for one access at a time. A requester presents an address, a write flag and write data. When the block is free it takes the request and walks through four phases in order: address setup, address hold, data, and data hold. After that it keeps the chip select high for a programmable turnaround time before it will start the next access.

Every phase length comes from a timing word. Reads and writes each have their own word, so the two directions can be tuned apart. The word is chosen by the write flag at the moment of acceptance and stays latched until the access ends. On a read, the data bus is sampled on the final cycle of the data phase. A one-cycle completion pulse marks the end of the data phase for reads and writes alike.

Top module: `amem_seq`

## Requirements
- R1: After a request is accepted, `cs_n` goes low in the next cycle. It stays low through the setup, hold, data and data-hold phases, in that order, and then goes high. `adv_n` is low only during the setup cycles.
- R2: The setup phase lasts as many cycles as the setup field. A setup field of 0 gives one cycle.
- R3: Both timing words use the same layout. Setup is in bits [3:0] and address hold is in [7:4]; both are in cycles, and a hold of 0 skips the phase. Data phase is in [15:8]; a value of 0 gives one cycle. Data hold is in [17:16]. Turnaround is in [21:18].
- R4: On a read, data hold lasts exactly the field value, and 0 skips it. On a write, data hold lasts the field value plus one cycle.
- R5: A read takes all its phase lengths from `rd_timing` and a write takes them from `wr_timing`. Both are captured on the accepting clock edge.
- R6: `oe_n` is low only during the data phase of a read. `we_n` is low only during the data phase of a write. The two are never low together.
- R7: On a read, `rd_data` takes the value of `mem_din` from the last data-phase cycle. `done` is high for exactly one cycle, the cycle after the last data-phase cycle, on both reads and writes.
- R8: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. A request made while `busy` is high is ignored. `busy` is high from the first setup cycle until the last turnaround cycle; in that last cycle it is low.
- R9: Once an access ends, `cs_n` stays high for the turnaround count before the next access can assert it. A turnaround of 0 gives one idle cycle when requests come back to back.
- R10: While `cs_n` is low, `mem_addr` holds the accepted address. `mem_dout_en` is high exactly while `cs_n` is low on a write, and `mem_dout` then holds the accepted write data.
- R11: While reset is held, `cs_n`, `adv_n`, `oe_n` and `we_n` are high, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_timing | input | 22 | Phase lengths used for reads |
| wr_timing | input | 22 | Phase lengths used for writes |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | High when a new request cannot be taken |
| done | output | 1 | One-cycle pulse after the data phase |
| rd_data | output | DW | Captured read data |
| mem_addr | output | AW | Address to the device |
| mem_dout | output | DW | Write data to the device |
| mem_dout_en | output | 1 | Drive enable for the device data bus |
| mem_din | input | DW | Read data from the device |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low, during setup |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
Two functions can fall in the same cycle. The last turnaround cycle of one access can also be the cycle that accepts the next request. The completion pulse of one access can also coincide with the idle cycle in which the following request is taken. The bench provokes both by holding `req_valid` high across access boundaries, with turnaround and data hold set to zero, and then to non-zero values. A behavioural queue model predicts every strobe, `busy` and `done` cycle by cycle. It flags any cycle in which the new setup begins one cycle too early or too late, or in which the pulse is lost.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int SET_W  = 4;
    localparam int HOLD_W = 4;
    localparam int DATA_W = 8;
    localparam int DH_W   = 2;
    localparam int TURN_W = 4;
    localparam int TIM_W  = SET_W + HOLD_W + DATA_W + DH_W + TURN_W;
    localparam int CNT_W  = DATA_W;

    // Timing word layout, LSB first: setup, hold, data, data hold, turnaround
    typedef struct packed {
        logic [TURN_W-1:0] turn;
        logic [DH_W-1:0]   dhold;
        logic [DATA_W-1:0] data;
        logic [HOLD_W-1:0] hold;
        logic [SET_W-1:0]  setup;
    } tim_word_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] data;
        logic [CNT_W-1:0] dhold;
        logic [CNT_W-1:0] turn;
    } phase_len_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_HOLD  = 3'd2,
        PH_DATA  = 3'd3,
        PH_DHOLD = 3'd4,
        PH_TURN  = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } phase_step_t;

    // Normalise a raw word into cycle counts for one access direction
    function automatic phase_len_t expand_word(tim_word_t w, logic is_wr);
        phase_len_t r;
        r.setup = (w.setup == '0) ? CNT_W'(1) : CNT_W'(w.setup);
        r.hold  = CNT_W'(w.hold);
        r.data  = (w.data == '0) ? CNT_W'(1) : CNT_W'(w.data);
        r.dhold = is_wr ? (CNT_W'(w.dhold) + CNT_W'(1)) : CNT_W'(w.dhold);
        r.turn  = CNT_W'(w.turn);
        return r;
    endfunction

    // Phase that follows the current one, skipping zero-length phases
    function automatic phase_step_t step_after(phase_e cur, phase_len_t l);
        phase_step_t s;
        s.ph  = PH_IDLE;
        s.cnt = '0;
        case (cur)
            PH_SETUP: begin
                if (l.hold != '0) begin s.ph = PH_HOLD; s.cnt = l.hold; end
                else begin s.ph = PH_DATA; s.cnt = l.data; end
            end
            PH_HOLD: begin
                s.ph = PH_DATA; s.cnt = l.data;
            end
            PH_DATA: begin
                if (l.dhold != '0) begin s.ph = PH_DHOLD; s.cnt = l.dhold; end
                else if (l.turn != '0) begin s.ph = PH_TURN; s.cnt = l.turn; end
            end
            PH_DHOLD: begin
                if (l.turn != '0) begin s.ph = PH_TURN; s.cnt = l.turn; end
            end
            default: begin
                s.ph  = PH_IDLE;
                s.cnt = '0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/amem_timing_sel.sv
module amem_timing_sel
    import amem_pkg::*;
(
    input  logic             req_write,
    input  logic [TIM_W-1:0] rd_word,
    input  logic [TIM_W-1:0] wr_word,
    output phase_len_t       sel_len
);

    tim_word_t raw;

    always_comb begin
        raw     = req_write ? tim_word_t'(wr_word) : tim_word_t'(rd_word);
        sel_len = expand_word(raw, req_write);
    end

endmodule

// File: rtl/amem_phase_ctl.sv
module amem_phase_ctl
    import amem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  phase_len_t new_len,
    output phase_e     phase,
    output logic       accept,
    output logic       ready,
    output logic       is_wr,
    output logic       data_last
);

    logic [CNT_W-1:0] cnt;
    phase_len_t       len_q;
    phase_step_t      nxt;

    always_comb begin
        ready     = (phase == PH_IDLE) || ((phase == PH_TURN) && (cnt == CNT_W'(1)));
        accept    = req_valid && ready;
        data_last = (phase == PH_DATA) && (cnt == CNT_W'(1));
        nxt       = step_after(phase, len_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            len_q <= '0;
            is_wr <= 1'b0;
        end else if (accept) begin
            phase <= PH_SETUP;
            cnt   <= new_len.setup;
            len_q <= new_len;
            is_wr <= req_write;
        end else if (phase != PH_IDLE) begin
            if (cnt == CNT_W'(1)) begin
                phase <= nxt.ph;
                cnt   <= nxt.cnt;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (cnt != '0)); // R1
    AST_ACCEPT_SETUP: assert property (@(posedge clk) disable iff (rst)
        accept |=> (phase == PH_SETUP)); // R8
    AST_WR_DHOLD: assert property (@(posedge clk) disable iff (rst)
        (data_last && is_wr && !accept) |=> (phase == PH_DHOLD)); // R4

endmodule

// File: rtl/amem_strobes.sv
module amem_strobes
    import amem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic          is_wr,
    input  logic          accept,
    input  logic          data_last,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_din,
    output logic          cs_n,
    output logic          adv_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    output logic [DW-1:0] rd_data,
    output logic          done
);

    logic active;

    always_comb begin
        active      = (phase == PH_SETUP) || (phase == PH_HOLD) ||
                      (phase == PH_DATA)  || (phase == PH_DHOLD);
        cs_n        = !active;
        adv_n       = (phase != PH_SETUP);
        oe_n        = !((phase == PH_DATA) && !is_wr);
        we_n        = !((phase == PH_DATA) && is_wr);
        mem_dout_en = active && is_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= data_last;
            if (data_last && !is_wr) begin
                rd_data <= mem_din;
            end
        end
    end

    AST_NO_DUAL_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n)); // R6
    AST_ENABLE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || !we_n) |-> !cs_n); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && !$past(accept)) |-> $stable(mem_addr)); // R10

endmodule

// File: rtl/amem_seq.sv
module amem_seq
    import amem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TIM_W-1:0] rd_timing,
    input  logic [TIM_W-1:0] wr_timing,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_dout_en,
    input  logic [DW-1:0]    mem_din,
    output logic             cs_n,
    output logic             adv_n,
    output logic             oe_n,
    output logic             we_n
);

    phase_len_t sel_len;
    phase_e     phase;
    logic       accept;
    logic       ready;
    logic       is_wr;
    logic       data_last;

    amem_timing_sel u_sel (
        .req_write (req_write),
        .rd_word   (rd_timing),
        .wr_word   (wr_timing),
        .sel_len   (sel_len)
    );

    amem_phase_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .new_len   (sel_len),
        .phase     (phase),
        .accept    (accept),
        .ready     (ready),
        .is_wr     (is_wr),
        .data_last (data_last)
    );

    amem_strobes #(.AW(AW), .DW(DW)) u_stb (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .is_wr       (is_wr),
        .accept      (accept),
        .data_last   (data_last),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .mem_din     (mem_din),
        .cs_n        (cs_n),
        .adv_n       (adv_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en),
        .rd_data     (rd_data),
        .done        (done)
    );

    assign busy = !ready;

    AST_CS_OPENS_WITH_ADV: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !adv_n); // R1
    AST_BUSY_WHILE_CS: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy); // R8

endmodule

// File: tb/sim_amem_seq.sv
`timescale 1ns/1ps
module sim_amem_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] rd_timing = '0;
    logic [21:0] wr_timing = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mem_dout_en, cs_n, adv_n, oe_n, we_n;
    logic [15:0] rd_data, mem_addr, mem_dout;
    logic [15:0] mem_din = 16'h1234;

    int errors = 0;
    int checks = 0;
    int acc_count = 0;
    int cyc = 0;
    logic [15:0] exp_rd = '0;
    logic        exp_busy;

    typedef struct packed {
        logic cs, adv, oe, we, busy, done, sample, wr;
        logic [15:0] addr, wdata;
    } ent_t;

    ent_t q[$];
    localparam ent_t IDLE_E = '{cs:1'b1, adv:1'b1, oe:1'b1, we:1'b1, busy:1'b0,
                                done:1'b0, sample:1'b0, wr:1'b0, addr:16'h0, wdata:16'h0};

    always #2 clk = ~clk;

    amem_seq u0 (
        .clk(clk), .rst(rst), .rd_timing(rd_timing), .wr_timing(wr_timing),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n)
    );

    function automatic logic [21:0] mk(int turn, int dh, int data, int hold, int setup);
        return {4'(turn), 2'(dh), 8'(data), 4'(hold), 4'(setup)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Build the per-cycle expectation of one accepted access
    function automatic void push_access(bit wr, logic [15:0] a, logic [15:0] d);
        logic [21:0] w;
        int s, h, dl, dh, t, idx;
        ent_t e;
        w  = wr ? wr_timing : rd_timing;
        s  = (w[3:0] == 0) ? 1 : int'(w[3:0]);
        h  = int'(w[7:4]);
        dl = (w[15:8] == 0) ? 1 : int'(w[15:8]);
        dh = wr ? int'(w[17:16]) + 1 : int'(w[17:16]);
        t  = int'(w[21:18]);
        e = IDLE_E;
        e.busy = 1'b1; e.wr = wr; e.addr = a; e.wdata = d; e.cs = 1'b0;
        for (int i = 0; i < s; i++) begin e.adv = 1'b0; q.push_back(e); end
        e.adv = 1'b1;
        for (int i = 0; i < h; i++) q.push_back(e);
        for (int i = 0; i < dl; i++) begin
            ent_t x;
            x = e;
            x.oe = wr; x.we = !wr;
            x.sample = (i == dl - 1) && !wr;
            q.push_back(x);
        end
        for (int i = 0; i < dh; i++) q.push_back(e);
        for (int i = 0; i < t; i++) begin
            ent_t x;
            x = IDLE_E;
            x.busy = (i != t - 1);
            q.push_back(x);
        end
        idx = s + h + dl;
        if (idx < q.size()) begin
            ent_t x;
            x = q[idx]; x.done = 1'b1; q[idx] = x;
        end else begin
            ent_t x;
            x = IDLE_E; x.done = 1'b1;
            q.push_back(x);
        end
    endfunction

    // Reference model advance
    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            exp_busy = (q.size() > 0) ? q[0].busy : 1'b0;
            if (q.size() > 0) void'(q.pop_front());
            if (req_valid && !exp_busy) begin
                acc_count++;
                push_access(req_write, req_addr, req_wdata);
            end
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        ent_t x;
        x = (q.size() > 0) ? q[0] : IDLE_E;
        if (!rst) begin
            chk(cs_n === x.cs, "R1/R2/R3/R4/R5/R9 cs_n", int'(cs_n), int'(x.cs));
            chk(adv_n === x.adv, "R1/R2 adv_n", int'(adv_n), int'(x.adv));
            chk(oe_n === x.oe, "R6 oe_n", int'(oe_n), int'(x.oe));
            chk(we_n === x.we, "R6 we_n", int'(we_n), int'(x.we));
            chk(busy === x.busy, "R8 busy", int'(busy), int'(x.busy));
            chk(done === x.done, "R7 done", int'(done), int'(x.done));
            if (x.done) chk(rd_data === exp_rd, "R7 rd_data", int'(rd_data), int'(exp_rd));
            if (!x.cs) chk(mem_addr === x.addr, "R10 mem_addr", int'(mem_addr), int'(x.addr));
            chk(mem_dout_en === (!x.cs && x.wr), "R10 mem_dout_en",
                int'(mem_dout_en), int'(!x.cs && x.wr));
            if (!x.cs && x.wr) chk(mem_dout === x.wdata, "R10 mem_dout",
                int'(mem_dout), int'(x.wdata));
        end
        mem_din = mem_din * 16'd13 + 16'd7;
        if (q.size() > 0 && q[0].sample) exp_rd = mem_din;
    end

    task automatic req(input bit wr, input logic [15:0] a, input logic [15:0] d);
        int start;
        start = acc_count;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (acc_count == start);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d cycles", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(cs_n === 1'b1 && adv_n === 1'b1, "R11 cs_n/adv_n", int'({cs_n, adv_n}), 3);
        chk(oe_n === 1'b1 && we_n === 1'b1, "R11 oe_n/we_n", int'({oe_n, we_n}), 3);
        chk(busy === 1'b0 && done === 1'b0, "R11 busy/done", int'({busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 R5: distinct words, write uses all-zero word (R2 setup/data 0)
        rd_timing = mk(2, 1, 3, 1, 2);
        wr_timing = mk(0, 0, 0, 0, 0);
        req(1'b0, 16'h0100, 16'h0);
        wait_idle();
        req(1'b1, 16'h0200, 16'hBEEF);
        wait_idle();

        // R8 R9: back-to-back with turnaround expiring
        wr_timing = mk(3, 2, 2, 0, 1);
        req(1'b0, 16'h0300, 16'h0);
        req(1'b1, 16'h0301, 16'hCAFE);
        req(1'b0, 16'h0302, 16'h0);
        wait_idle();

        // R4 R7 R9: read with zero data hold and zero turnaround
        rd_timing = mk(0, 0, 2, 0, 3);
        req(1'b0, 16'h0400, 16'h0);
        req(1'b0, 16'h0401, 16'h0);
        req(1'b1, 16'h0402, 16'h5A5A);
        wait_idle();

        // R8: request during busy is ignored
        rd_timing = mk(3, 2, 4, 2, 1);
        req(1'b0, 16'h0500, 16'h0);
        req_valid = 1'b1; req_addr = 16'hDEAD; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // Mixed patterns
        for (int n = 0; n < 60; n++) begin
            rd_timing = mk($urandom % 4, $urandom % 4, $urandom % 6, $urandom % 3, $urandom % 4);
            wr_timing = mk($urandom % 4, $urandom % 4, $urandom % 6, $urandom % 3, $urandom % 4);
            req(1'($urandom % 2), 16'($urandom), 16'($urandom));
            if ($urandom % 3 == 0) wait_idle();
        end
        wait_idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule